// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block assembles one Ethernet frame in a byte-wide transmit buffer and then passes it to a transmit engine. The engine is controlled through a single descriptor word. When a request is accepted, the block sends a stop command to the engine and then a ring-pointer reload command. It then writes the frame into the buffer, one byte per cycle. The frame is the 14-byte header (destination, local station address, type), then the payload stream, then zero fill up to the minimum frame size.

After the last byte, the block writes a descriptor word that carries the ownership flag and the frame length, and it sends a start command. It then watches the ownership flag that the engine reports back. When the engine clears the flag, the block reports completion. At the same time it reports an error if the engine did not set the packet-good flag. If the flag is still set after a cycle budget set by a parameter, the block reports a timeout instead. Only one frame is in flight at a time.

Top module: `tx_frame_builder`

## Requirements
- R1: After reset, `busy`, `pay_ready`, `buf_we`, all four engine commands, `desc_word`, `done`, `tx_err` and `tx_timeout` are all low.
- R2: `req` is accepted only while `busy` is low. A `req` pulse raised while a frame is in progress has no effect: no second command sequence follows, and `busy` stays low after `done`.
- R3: `xmit_stop` pulses one cycle after the accepting cycle, and `ring_load` pulses in the cycle after that. No two engine commands are ever high together.
- R4: The header is written to buffer addresses 0 to 13. It is the destination address with its most significant byte first, then the local address in the same order, then the type with its high byte first.
- R5: Payload bytes go to consecutive addresses from 14 upward, one per cycle in which `pay_valid` and `pay_ready` are both high. `pay_ready` is high only while payload is expected.
- R6: When header plus payload is shorter than 60 bytes, zero bytes are written at the following addresses until 60 bytes have been written.
- R7: In the cycle after the last buffer write, `desc_we` pulses with `desc_word` holding bit 31 (ownership) set, bits 11:0 holding the frame length and all other bits zero. `xmit_start` pulses in the next cycle.
- R8: The frame length is (`pay_len` + 14) modulo 4096, raised to 60 if it is smaller. A 46-byte payload gives exactly 60 and no padding.
- R9: Once the block is waiting, the first cycle in which `desc_rdata` bit 31 is low is followed one cycle later by a one-cycle `done`. `tx_err` pulses together with `done` exactly when `desc_rdata` bit 27 (packet good) was low in that cycle.
- R10: If `desc_rdata` bit 31 stays high for `TIMEOUT_CYC` waiting cycles, `done` and `tx_timeout` pulse together one cycle later, `tx_err` stays low, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start building a frame (sampled when idle) |
| dst_addr | input | 48 | Destination station address |
| src_addr | input | 48 | Local station address |
| eth_type | input | 16 | Frame type field |
| pay_len | input | 12 | Payload length in bytes |
| pay_valid | input | 1 | Payload byte available |
| pay_data | input | 8 | Payload byte |
| pay_ready | output | 1 | Block is consuming payload bytes |
| busy | output | 1 | A frame is in progress |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 12 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| xmit_stop | output | 1 | Transmitter-off command pulse |
| ring_load | output | 1 | Descriptor pointer reload pulse |
| desc_we | output | 1 | Descriptor word write strobe |
| desc_word | output | 32 | Descriptor word (ownership and length) |
| xmit_start | output | 1 | Transmitter-on command pulse |
| desc_rdata | input | 32 | Descriptor status read back from the engine |
| done | output | 1 | Frame finished (one cycle) |
| tx_err | output | 1 | Packet-good flag was clear at completion |
| tx_timeout | output | 1 | Ownership flag never cleared within the budget |

## Verification
The checker watches the structure of the handshake on every cycle. It checks that commands never overlap, that stop is followed by reload and descriptor write by start, and that each descriptor word carries ownership and a length of at least the minimum. It also checks that padded bytes are zero and that error or timeout never appears without done. The byte order of the header, the payload placement under gaps in `pay_valid`, the exact length value, the completion latency measured from the release of ownership, the timeout budget and the ignoring of a request during a frame can only be shown by the bench's frame scenarios against its reference model.

// File: rtl/tfb_pkg.sv
// Shared constants and state type for the transmit frame builder.
package tfb_pkg;
    localparam int TFB_MAC_W     = 48;
    localparam int TFB_TYPE_W    = 16;
    localparam int TFB_HDR_BYTES = (2 * TFB_MAC_W + TFB_TYPE_W) / 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STOP,
        S_LOAD,
        S_HDR,
        S_PAY,
        S_PAD,
        S_DESC,
        S_ON,
        S_WAIT
    } tfb_state_e;
endpackage

// File: rtl/tfb_hdr_sel.sv
// Header byte selector.
// Returns byte number `sel` of the header {dst, src, etype}, most
// significant byte first. Assumes sel stays below the header size while
// the header is being written; any other value returns zero.
module tfb_hdr_sel #(
    parameter int MAC_W  = 48,
    parameter int TYPE_W = 16,
    parameter int SEL_W  = 4
) (
    input  logic [MAC_W-1:0]  dst,
    input  logic [MAC_W-1:0]  src,
    input  logic [TYPE_W-1:0] etype,
    input  logic [SEL_W-1:0]  sel,
    output logic [7:0]        byte_o
);
    localparam int VEC_W  = 2 * MAC_W + TYPE_W;
    localparam int NBYTES = VEC_W / 8;

    logic [VEC_W-1:0] hdr_vec;
    logic [7:0]       lane [NBYTES];

    assign hdr_vec = {dst, src, etype};

    // Split the header vector into byte lanes, first transmitted byte at lane 0.
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign lane[g] = hdr_vec[8*(NBYTES-1-g) +: 8];
    end

    // Pick the lane addressed by the byte counter.
    always_comb begin
        byte_o = 8'h00;
        if (int'(sel) < NBYTES) byte_o = lane[sel];
    end
endmodule

// File: rtl/tfb_len_calc.sv
// Frame length calculator.
// Adds the header size to the payload length, wraps the sum to LEN_W bits
// and raises the result to the minimum frame size. Purely combinational.
module tfb_len_calc #(
    parameter int LEN_W     = 12,
    parameter int HDR_BYTES = 14,
    parameter int MIN_FRAME = 60
) (
    input  logic [LEN_W-1:0] pay_len,
    output logic [LEN_W-1:0] frame_len
);
    localparam logic [LEN_W-1:0] HDR_L = LEN_W'(HDR_BYTES);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);

    logic [LEN_W-1:0] raw_len;

    // Header plus payload, wrapped to the length field width.
    assign raw_len = pay_len + HDR_L;

    // Raise short frames to the minimum size.
    assign frame_len = (raw_len < MIN_L) ? MIN_L : raw_len;
endmodule

// File: rtl/tfb_wait_timer.sv
// Completion wait timer.
// Counts cycles while `run` is high and raises `expire` in the cycle that is
// the LIMIT-th consecutive running cycle. Clears whenever `run` is low.
module tfb_wait_timer #(
    parameter int LIMIT = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    // Running-cycle counter, held at zero outside the wait phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);
endmodule

// File: rtl/tx_frame_builder.sv
// Transmit frame builder (top).
// Accepts one frame request while idle, stops the engine, reloads its
// descriptor pointer, writes header, payload and zero fill into the byte
// buffer, hands the frame over with one descriptor word, starts the engine
// and then polls the ownership flag until release or timeout.
// Assumes the engine keeps desc_rdata stable and valid while waiting.
module tx_frame_builder
    import tfb_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int DESC_W      = 32,
    parameter int OWN_BIT     = 31,
    parameter int OK_BIT      = 27,
    parameter int MIN_FRAME   = 60,
    parameter int TIMEOUT_CYC = 200_000_000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [TFB_MAC_W-1:0]  dst_addr,
    input  logic [TFB_MAC_W-1:0]  src_addr,
    input  logic [TFB_TYPE_W-1:0] eth_type,
    input  logic [LEN_W-1:0]      pay_len,
    input  logic                  pay_valid,
    input  logic [7:0]            pay_data,
    output logic                  pay_ready,
    output logic                  busy,
    output logic                  buf_we,
    output logic [LEN_W-1:0]      buf_addr,
    output logic [7:0]            buf_wdata,
    output logic                  xmit_stop,
    output logic                  ring_load,
    output logic                  desc_we,
    output logic [DESC_W-1:0]     desc_word,
    output logic                  xmit_start,
    input  logic [DESC_W-1:0]     desc_rdata,
    output logic                  done,
    output logic                  tx_err,
    output logic                  tx_timeout
);
    localparam int SEL_W = $clog2(TFB_HDR_BYTES);
    localparam logic [LEN_W-1:0] HDR_LAST = LEN_W'(TFB_HDR_BYTES - 1);
    localparam logic [LEN_W-1:0] MIN_L    = LEN_W'(MIN_FRAME);

    tfb_state_e              state;
    logic [TFB_MAC_W-1:0]    dst_q, src_q;
    logic [TFB_TYPE_W-1:0]   type_q;
    logic [LEN_W-1:0]        plen_q;
    logic [LEN_W-1:0]        idx, idx_nx, pcnt;
    logic [LEN_W-1:0]        frame_len;
    logic [7:0]              hdr_byte;
    logic                    expire;
    tfb_state_e              after_data;
    logic                    unused_status_bits;

    tfb_hdr_sel #(
        .MAC_W (TFB_MAC_W),
        .TYPE_W(TFB_TYPE_W),
        .SEL_W (SEL_W)
    ) u_hdr (
        .dst   (dst_q),
        .src   (src_q),
        .etype (type_q),
        .sel   (idx[SEL_W-1:0]),
        .byte_o(hdr_byte)
    );

    tfb_len_calc #(
        .LEN_W    (LEN_W),
        .HDR_BYTES(TFB_HDR_BYTES),
        .MIN_FRAME(MIN_FRAME)
    ) u_len (
        .pay_len  (plen_q),
        .frame_len(frame_len)
    );

    tfb_wait_timer #(
        .LIMIT(TIMEOUT_CYC)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_WAIT),
        .expire(expire)
    );

    assign idx_nx = idx + 1'b1;
    // Next phase after the last header or payload byte: fill or hand over.
    assign after_data = (idx_nx < MIN_L) ? S_PAD : S_DESC;
    assign unused_status_bits = ^desc_rdata;

    // Sequencer: request capture, buffer fill, handover and completion polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            dst_q      <= '0;
            src_q      <= '0;
            type_q     <= '0;
            plen_q     <= '0;
            idx        <= '0;
            pcnt       <= '0;
            done       <= 1'b0;
            tx_err     <= 1'b0;
            tx_timeout <= 1'b0;
        end else begin
            done       <= 1'b0;
            tx_err     <= 1'b0;
            tx_timeout <= 1'b0;
            case (state)
                S_IDLE: if (req) begin
                    dst_q  <= dst_addr;
                    src_q  <= src_addr;
                    type_q <= eth_type;
                    plen_q <= pay_len;
                    idx    <= '0;
                    pcnt   <= '0;
                    state  <= S_STOP;
                end
                S_STOP: state <= S_LOAD;
                S_LOAD: state <= S_HDR;
                S_HDR: begin
                    idx <= idx_nx;
                    if (idx == HDR_LAST) state <= (plen_q == '0) ? after_data : S_PAY;
                end
                S_PAY: if (pay_valid) begin
                    idx  <= idx_nx;
                    pcnt <= pcnt + 1'b1;
                    if (pcnt == plen_q - 1'b1) state <= after_data;
                end
                S_PAD: begin
                    idx <= idx_nx;
                    if (idx_nx >= MIN_L) state <= S_DESC;
                end
                S_DESC: state <= S_ON;
                S_ON:   state <= S_WAIT;
                S_WAIT: begin
                    if (!desc_rdata[OWN_BIT]) begin
                        done   <= 1'b1;
                        tx_err <= !desc_rdata[OK_BIT];
                        state  <= S_IDLE;
                    end else if (expire) begin
                        done       <= 1'b1;
                        tx_timeout <= 1'b1;
                        state      <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Buffer write port and engine commands decoded from the phase.
    always_comb begin
        busy       = (state != S_IDLE);
        pay_ready  = (state == S_PAY);
        xmit_stop  = (state == S_STOP);
        ring_load  = (state == S_LOAD);
        desc_we    = (state == S_DESC);
        xmit_start = (state == S_ON);
        buf_we     = (state == S_HDR) || (state == S_PAD) || ((state == S_PAY) && pay_valid);
        buf_addr   = idx;
        buf_wdata  = 8'h00;
        if (state == S_HDR)      buf_wdata = hdr_byte;
        else if (state == S_PAY) buf_wdata = pay_data;
        desc_word = '0;
        if (state == S_DESC) begin
            desc_word[OWN_BIT]     = 1'b1;
            desc_word[LEN_W-1:0]   = frame_len;
        end
    end
endmodule

// File: rtl/tfb_checker.sv
// Protocol checker for the transmit frame builder, bound to every instance.
module tfb_checker #(
    parameter int LEN_W     = 12,
    parameter int DESC_W    = 32,
    parameter int OWN_BIT   = 31,
    parameter int MIN_FRAME = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              pay_ready,
    input logic              buf_we,
    input logic [LEN_W-1:0]  buf_addr,
    input logic [7:0]        buf_wdata,
    input logic              xmit_stop,
    input logic              ring_load,
    input logic              desc_we,
    input logic [DESC_W-1:0] desc_word,
    input logic              xmit_start,
    input logic              done,
    input logic              tx_err,
    input logic              tx_timeout
);
    localparam logic [LEN_W-1:0] HDR_L = LEN_W'(tfb_pkg::TFB_HDR_BYTES);
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);

    p_stop_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_stop |-> $past(!busy));

    p_cmd_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xmit_stop, ring_load, desc_we, xmit_start}));

    p_stop_then_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_stop |=> ring_load);

    p_fill_is_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && !pay_ready && buf_addr >= HDR_L) |-> (buf_wdata == 8'h00));

    p_desc_then_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |=> xmit_start);

    p_desc_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> (desc_word[OWN_BIT] && desc_word[LEN_W-1:0] >= MIN_L));

    p_done_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> (done && !tx_timeout));

    p_timeout_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_timeout |-> done);
endmodule

bind tx_frame_builder tfb_checker #(
    .LEN_W    (LEN_W),
    .DESC_W   (DESC_W),
    .OWN_BIT  (OWN_BIT),
    .MIN_FRAME(MIN_FRAME)
) u_tfb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .pay_ready (pay_ready),
    .buf_we    (buf_we),
    .buf_addr  (buf_addr),
    .buf_wdata (buf_wdata),
    .xmit_stop (xmit_stop),
    .ring_load (ring_load),
    .desc_we   (desc_we),
    .desc_word (desc_word),
    .xmit_start(xmit_start),
    .done      (done),
    .tx_err    (tx_err),
    .tx_timeout(tx_timeout)
);

// File: tb/tx_frame_builder_test.sv
// Bench: behavioural reference (expected byte queue and event cycles) compared every cycle.
module tx_frame_builder_test;
    localparam int TMO = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [47:0] dst = '0, src = '0;
    logic [15:0] etype = '0;
    logic [11:0] plen = '0;
    logic        pay_valid = 1'b0;
    logic [7:0]  pay_data = '0;
    logic        pay_ready, busy, buf_we;
    logic [11:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        xmit_stop, ring_load, desc_we, xmit_start;
    logic [31:0] desc_word;
    logic [31:0] desc_rdata = '0;
    logic        done, tx_err, tx_timeout;

    always #10 clk = ~clk;

    tx_frame_builder #(.TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .dst_addr(dst), .src_addr(src),
        .eth_type(etype), .pay_len(plen), .pay_valid(pay_valid), .pay_data(pay_data),
        .pay_ready(pay_ready), .busy(busy), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .xmit_stop(xmit_stop), .ring_load(ring_load),
        .desc_we(desc_we), .desc_word(desc_word), .xmit_start(xmit_start),
        .desc_rdata(desc_rdata), .done(done), .tx_err(tx_err), .tx_timeout(tx_timeout)
    );

    int  errors = 0, checks = 0, cyc = 0;
    byte exp_q[$];
    int  wr_idx = 0, exp_len = 0, pay_idx = 0, pay_n = 0, rel_delay = 0;
    int  req_cyc = -1000, last_wr_cyc = -1000, desc_cyc = -1000, on_cyc = -1000, exp_done = -1000;
    bit  exp_err = 0, exp_tmo = 0, gaps = 0, req_go = 0, extra_req = 0, frame_done = 0;

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic byte pbyte(input int i);
        return byte'((i * 37 + 11) & 8'hFF);
    endfunction

    // Per cycle: drive inputs at the falling edge, then compare outputs with the model.
    always begin
        @(negedge clk);
        cyc++;
        req = 1'b0;
        if (req_go) begin req = 1'b1; req_go = 0; req_cyc = cyc; end
        if (extra_req && cyc == req_cyc + 6) req = 1'b1;
        if (pay_idx < pay_n && !(gaps && cyc % 3 == 0)) begin
            pay_valid = 1'b1; pay_data = pbyte(pay_idx);
        end else begin
            pay_valid = 1'b0; pay_data = 8'hA5;
        end
        if (rel_delay > 0 && cyc == on_cyc + rel_delay)
            desc_rdata = exp_err ? 32'h0000_0000 : 32'h0800_0000;
        if (pay_ready && pay_valid) pay_idx++;
        #2;
        if (rst_n) begin
            if (xmit_stop) begin
                chk("R3 stop cycle", cyc == req_cyc + 1, cyc, req_cyc + 1);
                chk("R2 busy while building", busy, busy, 1);
            end
            if (ring_load) chk("R3 reload cycle", cyc == req_cyc + 2, cyc, req_cyc + 2);
            if (buf_we) begin
                if (exp_q.size() == 0) chk("R5 unexpected buffer write", 0, buf_addr, 0);
                else begin
                    chk(wr_idx < 14 ? "R4 header address" : (wr_idx < pay_n + 14 ? "R5 payload address" : "R6 fill address"),
                        buf_addr == 12'(wr_idx), buf_addr, wr_idx);
                    chk(wr_idx < 14 ? "R4 header byte" : (wr_idx < pay_n + 14 ? "R5 payload byte" : "R6 fill byte"),
                        buf_wdata == exp_q[0], buf_wdata, exp_q[0]);
                    void'(exp_q.pop_front());
                    wr_idx++;
                    last_wr_cyc = cyc;
                end
            end
            if (desc_we) begin
                chk("R7 descriptor after last byte", exp_q.size() == 0 && cyc == last_wr_cyc + 1, cyc, last_wr_cyc + 1);
                chk("R7 descriptor word", desc_word == (32'h8000_0000 | 32'(exp_len)), desc_word, 32'h8000_0000 | 32'(exp_len));
                chk("R8 frame length", desc_word[11:0] == 12'(exp_len), desc_word[11:0], exp_len);
                desc_cyc = cyc;
                desc_rdata = 32'h8000_0000 | 32'(exp_len);
            end
            if (xmit_start) begin
                chk("R7 start after descriptor", cyc == desc_cyc + 1, cyc, desc_cyc + 1);
                on_cyc = cyc;
                exp_done = (rel_delay > 0) ? cyc + rel_delay + 1 : cyc + TMO + 1;
            end
            if (done) begin
                chk(exp_tmo ? "R10 timeout latency" : "R9 done latency", cyc == exp_done, cyc, exp_done);
                chk("R9 error flag", tx_err == exp_err, tx_err, exp_err);
                chk("R10 timeout flag", tx_timeout == exp_tmo, tx_timeout, exp_tmo);
                frame_done = 1;
                on_cyc = -1000;
            end else begin
                if (tx_err) chk("R9 error without done", 0, 1, 0);
                if (tx_timeout) chk("R10 timeout without done", 0, 1, 0);
            end
        end
    end

    task automatic run_frame(input logic [47:0] d, input logic [47:0] s, input logic [15:0] t,
                             input int n, input int rel, input bit ok, input bit g, input bit extra);
        dst = d; src = s; etype = t; plen = 12'(n);
        exp_q.delete();
        for (int k = 0; k < 6; k++) exp_q.push_back(byte'(d[47-8*k -: 8]));
        for (int k = 0; k < 6; k++) exp_q.push_back(byte'(s[47-8*k -: 8]));
        exp_q.push_back(byte'(t[15:8]));
        exp_q.push_back(byte'(t[7:0]));
        for (int k = 0; k < n; k++) exp_q.push_back(pbyte(k));
        while (exp_q.size() < 60) exp_q.push_back(8'h00);
        exp_len = exp_q.size();
        wr_idx = 0; pay_idx = 0; pay_n = n; gaps = g; rel_delay = rel;
        exp_tmo = (rel == 0); exp_err = (rel == 0) ? 1'b0 : !ok;
        extra_req = extra; frame_done = 0; desc_rdata = '0;
        req_go = 1;
        while (!frame_done) @(negedge clk);
        repeat (4) @(negedge clk);
        #3;
        chk("R2 idle after done", !busy && !xmit_stop, busy, 0);
        chk("R2 all bytes written", exp_q.size() == 0, exp_q.size(), 0);
        extra_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #3;
        chk("R1 reset outputs", {busy, pay_ready, buf_we, xmit_stop, ring_load, desc_we, xmit_start, done, tx_err, tx_timeout} == 10'b0,
            {busy, pay_ready, buf_we, xmit_stop, ring_load, desc_we, xmit_start, done, tx_err, tx_timeout}, 0);
        chk("R1 reset descriptor", desc_word == 32'h0, desc_word, 0);
        // Short payload with fill, success, plus a request while busy (R2, R6).
        run_frame(48'h0011_2233_4455, 48'h0A0B_0C0D_0E0F, 16'h0800, 5, 3, 1, 0, 1);
        // Long payload with input gaps, packet-good clear (R5, R9).
        run_frame(48'hFFFF_FFFF_FFFF, 48'h0212_3456_789A, 16'h86DD, 50, 6, 0, 1, 0);
        // Exactly minimum length, no fill (R8).
        run_frame(48'hA1B2_C3D4_E5F6, 48'h1122_3344_5566, 16'h0806, 46, 1, 1, 1, 0);
        // Empty payload (R6).
        run_frame(48'h0102_0304_0506, 48'h6050_4030_2010, 16'h88B5, 0, 2, 1, 0, 0);
        // Engine never releases ownership (R10).
        run_frame(48'hDEAD_BEEF_0001, 48'h0A0B_0C0D_0E0F, 16'h0800, 10, 0, 1, 0, 0);
        // Recovery after timeout.
        run_frame(48'h1234_5678_9ABC, 48'h0A0B_0C0D_0E0F, 16'h0801, 3, 4, 1, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule